// File: doc/BRIEF.md
# Masked Keypad Interrupt Controller

This block tracks which of up to sixteen keys are held down and raises an active-low interrupt towards the host when a key that is not masked goes down. Key activity arrives as single-cycle events. Each event carries a key index and a flag that says whether the key went down or came up. No matrix scanning or debounce timing happens here. The stored debounce code is only kept for readback.

The host reaches four 16-bit registers through a simple read/write strobe interface. The registers are the pressed-key bitmap, a control word holding a scan-enable bit and a debounce code, the key mask, and a configuration word holding a 2-bit clear-policy mode. The interrupt can be withdrawn in three ways, each chosen by policy. It can be withdrawn when the host reads the bitmap, when the host writes the control word with scan enabled, or when no unmasked key is still held. When an event and a register access share a cycle, the event takes effect first. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `kp_intc`

## Requirements
- R1: While reset is applied and after it is released, `kint_n` is high. Control reads 0x4000 (scan enabled, debounce 0, no interrupt). The mask reads 0x0000. The configuration word reads 0x4000 (mode = 3). Register select codes: 0 = key bitmap, 1 = control, 2 = mask, 3 = configuration.
- R2: A key event with `key_down` = 1 sets bit `key_idx` of the bitmap, and one with `key_down` = 0 clears it. A read of select 0 returns the bitmap.
- R3: A key-down event that leaves at least one unmasked key held, with no interrupt pending, sets the interrupt, and `kint_n` is low on the following cycle.
- R4: The interrupt is only ever set by a key-down event. Pressing keys whose mask bit is 1, while no unmasked key is held, leaves `kint_n` high.
- R5: On a key event that leaves no unmasked key held, a pending interrupt clears when mode bit 0 is 0. It stays pending when mode bit 0 is 1.
- R6: A read of the bitmap clears a pending interrupt when mode bit 1 is 1. It has no effect on the interrupt when mode bit 1 is 0.
- R7: A write to the control word loads scan enable from bit 14 and the debounce code from bits 13:11. If the written scan bit is 1, a pending interrupt clears. If it is 0, a pending interrupt stays.
- R8: Control readback places the interrupt flag at bit 15. Bit 14 reads as scan enable OR "no key held". Bits 13:11 hold the debounce code, and all other bits read 0.
- R9: A write to the configuration word loads the mode from bits 15:14. Its readback shows mode bit 0 at bit 14, with all other bits 0.
- R10: When a key event and a register access fall in the same cycle, the event is applied first. The read data, the clear decisions and the readback flags all see the post-event state. Read data is valid on the cycle after `reg_rd`.
- R11: Writes to the key bitmap register are ignored, and the bitmap reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_evt | input | 1 | One-cycle key event strobe |
| key_idx | input | 4 | Index of the key in the event |
| key_down | input | 1 | 1 = key went down, 0 = key came up |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 bitmap, 1 control, 2 mask, 3 configuration) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered, valid the cycle after `reg_rd` |
| kint_n | output | 1 | Keypad interrupt, active low |

## Verification
Two things can collide in one cycle: a key event, and a host access that reads the bitmap or rewrites the control or mask word. The bench forces these collisions in directed steps, such as a press together with a bitmap read or a release together with a scan-enabling write. It then runs a long random stretch in which events and accesses overlap freely. A behavioural model applies the event before the access, and each cycle the interrupt pin and the read data are compared against it. Any difference in ordering shows up as a wrong bitmap value, a wrong bit 14 or 15 in the readback, or an interrupt that should have cleared but did not.

// File: rtl/kp_pkg.sv
package kp_pkg;
   typedef enum logic [1:0] {
      KP_SEL_KEYS = 2'd0,
      KP_SEL_CTRL = 2'd1,
      KP_SEL_MASK = 2'd2,
      KP_SEL_CFG  = 2'd3
   } kp_sel_e;

   // Field positions decoded by host software
   localparam int KP_INTR_BIT = 15;
   localparam int KP_SCAN_BIT = 14;
   localparam int KP_DEB_LSB  = 11;
   localparam int KP_DEB_W    = KP_SCAN_BIT - KP_DEB_LSB;
   localparam int KP_MODE_LSB = 14;
   localparam int KP_MODE_W   = 2;
endpackage

// File: rtl/kp_keymap.sv
module kp_keymap #(
   parameter int NUM_KEYS = 16,
   parameter int IDX_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt,
   input  logic [IDX_W-1:0]    idx,
   input  logic                down,
   output logic [NUM_KEYS-1:0] keys_nxt
);
   logic [NUM_KEYS-1:0] keys_q;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      logic hit;
      assign hit         = evt && (idx == IDX_W'(k));
      assign keys_nxt[k] = hit ? down : keys_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) keys_q <= '0;
      else        keys_q <= keys_nxt;
   end
endmodule

// File: rtl/kp_irq.sv
module kp_irq #(
   parameter int NUM_KEYS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt,
   input  logic                down,
   input  logic [NUM_KEYS-1:0] keys_nxt,
   input  logic [NUM_KEYS-1:0] mask,
   input  logic                hold_mode,
   input  logic                rd_clr,
   input  logic                wr_clr,
   output logic                intr_evt,
   output logic                intr_q
);
   logic any_unmasked;
   assign any_unmasked = |(keys_nxt & ~mask);

   always_comb begin
      intr_evt = intr_q;
      if (evt) begin
         if (down && any_unmasked && !intr_q)
            intr_evt = 1'b1;
         else if (intr_q && !any_unmasked && !hold_mode)
            intr_evt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) intr_q <= 1'b0;
      else        intr_q <= intr_evt && !rd_clr && !wr_clr;
   end
endmodule

// File: rtl/kp_regs.sv
module kp_regs
   import kp_pkg::*;
#(
   parameter int NUM_KEYS = 16,
   parameter int DATA_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  logic                wr,
   input  kp_sel_e             sel,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [NUM_KEYS-1:0] keys_nxt,
   input  logic                intr_evt,
   output logic [NUM_KEYS-1:0] mask_q,
   output logic [KP_MODE_W-1:0] mode_q,
   output logic                rd_clr,
   output logic                wr_clr,
   output logic [DATA_W-1:0]   rdata
);
   logic                scan_q;
   logic [KP_DEB_W-1:0] deb_q;
   logic [DATA_W-1:0]   keys_ext, mask_ext, rd_val;

   if (NUM_KEYS == DATA_W) begin : g_nopad
      assign keys_ext = keys_nxt;
      assign mask_ext = mask_q;
   end else begin : g_pad
      assign keys_ext = {{(DATA_W-NUM_KEYS){1'b0}}, keys_nxt};
      assign mask_ext = {{(DATA_W-NUM_KEYS){1'b0}}, mask_q};
   end

   assign rd_clr = rd && (sel == KP_SEL_KEYS) && mode_q[1];
   assign wr_clr = wr && (sel == KP_SEL_CTRL) && wdata[KP_SCAN_BIT];

   always_comb begin
      rd_val = '0;
      unique case (sel)
         KP_SEL_KEYS: rd_val = keys_ext;
         KP_SEL_CTRL: begin
            rd_val[KP_INTR_BIT] = intr_evt;
            rd_val[KP_SCAN_BIT] = scan_q || (keys_nxt == '0);
            rd_val[KP_DEB_LSB +: KP_DEB_W] = deb_q;
         end
         KP_SEL_MASK: rd_val = mask_ext;
         KP_SEL_CFG:  rd_val[KP_MODE_LSB] = mode_q[0];
         default:     rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q <= 1'b1;
         deb_q  <= '0;
         mask_q <= '0;
         mode_q <= 2'b11;
         rdata  <= '0;
      end else begin
         if (rd) rdata <= rd_val;
         if (wr) begin
            unique case (sel)
               KP_SEL_CTRL: begin
                  scan_q <= wdata[KP_SCAN_BIT];
                  deb_q  <= wdata[KP_DEB_LSB +: KP_DEB_W];
               end
               KP_SEL_MASK: mask_q <= wdata[NUM_KEYS-1:0];
               KP_SEL_CFG:  mode_q <= wdata[KP_MODE_LSB +: KP_MODE_W];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/kp_intc.sv
module kp_intc
   import kp_pkg::*;
#(
   parameter int NUM_KEYS = 16,
   parameter int DATA_W   = 16,
   localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_evt,
   input  logic [IDX_W-1:0]  key_idx,
   input  logic              key_down,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              kint_n
);
   if (NUM_KEYS > DATA_W || NUM_KEYS < 1) begin : g_bad_keys
      $error("kp_intc: NUM_KEYS must be 1..DATA_W");
   end
   if (DATA_W < KP_INTR_BIT + 1) begin : g_bad_width
      $error("kp_intc: DATA_W too narrow for control fields");
   end

   logic [NUM_KEYS-1:0]  keys_nxt, mask_r;
   logic [KP_MODE_W-1:0] mode_r;
   logic                 intr_evt, intr_r, rd_clr, wr_clr;

   kp_keymap #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_map (
      .clk(clk), .rst_n(rst_n), .evt(key_evt), .idx(key_idx),
      .down(key_down), .keys_nxt(keys_nxt)
   );

   kp_irq #(.NUM_KEYS(NUM_KEYS)) u_irq (
      .clk(clk), .rst_n(rst_n), .evt(key_evt), .down(key_down),
      .keys_nxt(keys_nxt), .mask(mask_r), .hold_mode(mode_r[0]),
      .rd_clr(rd_clr), .wr_clr(wr_clr), .intr_evt(intr_evt), .intr_q(intr_r)
   );

   kp_regs #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr),
      .sel(kp_sel_e'(reg_sel)), .wdata(reg_wdata), .keys_nxt(keys_nxt),
      .intr_evt(intr_evt), .mask_q(mask_r), .mode_q(mode_r),
      .rd_clr(rd_clr), .wr_clr(wr_clr), .rdata(reg_rdata)
   );

   assign kint_n = ~intr_r;
endmodule

// File: rtl/kp_intc_chk.sv
module kp_intc_chk #(
   parameter int NUM_KEYS = 16,
   parameter int IDX_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                key_evt,
   input logic [IDX_W-1:0]    key_idx,
   input logic                key_down,
   input logic                reg_rd,
   input logic                reg_wr,
   input logic [1:0]          reg_sel,
   input logic                wr_scan,
   input logic                kint_n,
   input logic [NUM_KEYS-1:0] mask,
   input logic [1:0]          mode
);
   logic scan_clr, read_clr;
   assign scan_clr = reg_wr && reg_sel == 2'd1 && wr_scan;
   assign read_clr = reg_rd && reg_sel == 2'd0 && mode[1];

   AST_RESET_PIN_HIGH: assert property (@(posedge clk) !rst_n |=> kint_n); // R1

   AST_UNMASKED_PRESS_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      key_evt && key_down && !mask[key_idx] && !scan_clr && !read_clr |=> !kint_n); // R3

   AST_NO_SPONTANEOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      kint_n && !(key_evt && key_down) |=> kint_n); // R4

   AST_HOLD_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !kint_n && mode[0] && !reg_rd && !reg_wr |=> !kint_n); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !kint_n && read_clr |=> kint_n); // R6

   AST_SCAN_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      scan_clr |=> kint_n); // R7
endmodule

bind kp_intc kp_intc_chk #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .key_evt(key_evt), .key_idx(key_idx),
   .key_down(key_down), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .wr_scan(reg_wdata[14]), .kint_n(kint_n), .mask(mask_r), .mode(mode_r)
);

// File: tb/tb_kp_intc.sv
module tb_kp_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_evt = 1'b0, key_down = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
   logic [3:0]  key_idx = '0;
   logic [1:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        kint_n;

   kp_intc dut (.*);

   always #2 clk = ~clk;

   // behavioural reference
   int    m_keys = 0, m_mask = 0, m_mode = 3, m_scan = 1, m_deb = 0, m_intr = 0;
   int    m_rdata = 0;
   bit    m_rd_seen = 0;
   int    vectors = 0, miscompares = 0;
   string cur_req = "R1";
   bit    done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_keys = 0; m_mask = 0; m_mode = 3; m_scan = 1; m_deb = 0; m_intr = 0;
         m_rd_seen = 0;
      end else begin
         int un;
         bit clr;
         clr = 0;
         if (key_evt) begin
            if (key_down) m_keys = m_keys | (1 << key_idx);
            else          m_keys = m_keys & ~(1 << key_idx);
            un = m_keys & ~m_mask & 16'hffff;
            if (key_down && un != 0 && m_intr == 0) m_intr = 1;
            else if (m_intr == 1 && un == 0 && (m_mode & 1) == 0) m_intr = 0;
         end
         m_rd_seen = reg_rd;
         if (reg_rd) begin
            case (reg_sel)
               2'd0: begin m_rdata = m_keys; if ((m_mode & 2) != 0) clr = 1; end
               2'd1: m_rdata = (m_intr << 15) | (((m_scan != 0) || (m_keys == 0)) << 14) | (m_deb << 11);
               2'd2: m_rdata = m_mask;
               default: m_rdata = (m_mode & 1) << 14;
            endcase
         end
         if (clr) m_intr = 0;
         if (reg_wr) begin
            case (reg_sel)
               2'd1: begin
                  m_scan = reg_wdata[14];
                  m_deb  = reg_wdata[13:11];
                  if (m_scan != 0) m_intr = 0;
               end
               2'd2: m_mask = reg_wdata;
               2'd3: m_mode = reg_wdata[15:14];
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         if (kint_n !== (m_intr == 0)) begin
            miscompares++;
            $display("FAIL %s kint_n actual=%0b expected=%0b t=%0t", cur_req, kint_n, m_intr == 0, $time);
         end
         if (rst_n && m_rd_seen) begin
            vectors++;
            if (reg_rdata !== m_rdata[15:0]) begin
               miscompares++;
               $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, reg_rdata, m_rdata[15:0], $time);
            end
         end
      end
   end

   task automatic cyc(input bit ev, input int idx, input bit dn,
                      input bit rd, input bit wr, input int sel, input int wd);
      @(negedge clk);
      key_evt = ev; key_idx = 4'(idx); key_down = dn;
      reg_rd = rd; reg_wr = wr; reg_sel = 2'(sel); reg_wdata = 16'(wd);
   endtask

   task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
   task automatic press(input int k);   cyc(1, k, 1, 0, 0, 0, 0); endtask
   task automatic release_k(input int k); cyc(1, k, 0, 0, 0, 0, 0); endtask
   task automatic rd(input int s); cyc(0, 0, 0, 1, 0, s, 0); endtask
   task automatic wr(input int s, input int d); cyc(0, 0, 0, 0, 1, s, d); endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired during %s", cur_req);
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(1); rd(2); rd(3); idle();
      // R2 R3: press unmasked key, bitmap readback
      cur_req = "R3"; press(3); idle();
      cur_req = "R2"; press(7); release_k(3); idle();
      cur_req = "R6"; rd(0); idle();            // mode bit 1 set: read clears
      // R5: release-all clear with mode bit 0 clear
      cur_req = "R9"; wr(3, 16'h0000); rd(3); idle();
      cur_req = "R5"; press(5); idle(); release_k(7); idle(); release_k(5); idle();
      // R4: masked key alone
      cur_req = "R4"; wr(2, 16'h0020); press(5); idle(); rd(2); release_k(5); idle();
      // R5: hold mode
      cur_req = "R5"; wr(3, 16'h4000); press(2); idle(); release_k(2); idle(); idle();
      cur_req = "R6"; rd(0); idle();            // mode bit 1 clear: no clear
      cur_req = "R8"; rd(1); idle();
      cur_req = "R7"; wr(1, 16'h1800); idle(); rd(1); idle();
      cur_req = "R8"; press(1); rd(1); idle();
      cur_req = "R7"; wr(1, 16'h4000); idle(); rd(1); idle();
      // R11: writes to the bitmap are ignored
      cur_req = "R11"; wr(0, 16'hffff); rd(0); idle();
      // R10: same-cycle event and access
      cur_req = "R10";
      wr(3, 16'hc000);
      cyc(1, 9, 1, 1, 0, 0, 0); idle();          // press with bitmap read
      cyc(1, 4, 1, 1, 0, 1, 0); idle();          // press with control read
      cyc(1, 4, 0, 0, 1, 1, 16'h4000); idle();   // release with scan write
      cyc(1, 11, 1, 0, 1, 2, 16'h0800); idle();  // press with mask write
      rd(1); idle();
      cur_req = "R9"; wr(3, 16'h8000); rd(3); idle();
      // mixed random traffic with collisions
      cur_req = "R10";
      for (int i = 0; i < 4000; i++) begin
         bit ev, dn, r, w;
         int s, d;
         ev = ($urandom % 2) == 0;
         dn = ($urandom % 3) != 0;
         r  = ($urandom % 3) == 0;
         w  = ($urandom % 6) == 0;
         s  = $urandom % 4;
         d  = $urandom % 65536;
         if (s == 2 && ($urandom % 2) == 0) d = d & 16'h00ff;
         cyc(ev, $urandom % 16, dn, r, w, s, d);
      end
      idle(); idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule